// File: doc/BRIEF.md
# Half-precision operand classifier

This block inspects one 16-bit binary16 floating-point value and reports which of ten categories it falls into. The answer is a one-hot mask: one bit each for negative infinity, negative normal, negative subnormal, negative zero, positive zero, positive subnormal, positive normal, positive infinity, signaling NaN and quiet NaN. The mask is zero-extended to an integer register width (`XLEN`), so it can be written straight into a general-purpose register by a floating-point execution pipe.

Operands enter over a valid/ready stream and results leave over a second valid/ready stream. With `REGISTERED=1` (the default) a single output stage holds the result. An input is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the stage is empty or its current result is being taken in the same cycle. This gives full throughput with no bubble. When `out_ready` is low and a result is held, `in_ready` drops, and the result and `out_valid` are frozen until the consumer takes them. With `REGISTERED=0` the classifier is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

The classifier produces no exception or status flags for any input, including signaling NaNs. The only output is the mask.

Top module: `half_class_unit`

## Requirements
- R1: An input with exponent field bits[14:10] all ones, mantissa bits[9:0] zero and sign bit[15] set (0xfc00) sets result bit 0 only.
- R2: A negative normal number (sign set, exponent neither all zeros nor all ones, e.g. 0xbc00 or 0xfbff) sets result bit 1 only.
- R3: A negative subnormal (sign set, exponent zero, mantissa nonzero, e.g. 0x83ff) sets bit 2 only, and negative zero (0x8000) sets bit 3 only.
- R4: Positive zero (0x0000) sets bit 4 only, and a positive subnormal (sign clear, exponent zero, mantissa nonzero, e.g. 0x03ff or 0x0001) sets bit 5 only.
- R5: A positive normal (e.g. 0x3c00, 0x0400, 0x7bff) sets bit 6 only, and positive infinity (0x7c00) sets bit 7 only.
- R6: A signaling NaN (exponent all ones, mantissa bit 9 clear, mantissa nonzero, either sign, e.g. 0x7c01 or 0xfc01) sets bit 8 only.
- R7: A quiet NaN (exponent all ones, mantissa bit 9 set, either sign, e.g. 0x7e00 or 0xfe00) sets bit 9 only.
- R8: For every one of the 65536 input patterns exactly one of result bits[9:0] is set and bits[XLEN-1:10] are zero.
- R9: With REGISTERED=1 the result for an accepted input appears with `out_valid` high on the clock edge after acceptance, and back-to-back inputs stream at one per cycle.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_result` hold their values and `in_ready` is low, so an input offered then is not accepted.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be accepted this cycle |
| in_data | input | 16 | binary16 operand (sign bit 15, exponent 14:10, mantissa 9:0) |
| out_valid | output | 1 | Class mask available |
| out_ready | input | 1 | Consumer takes the mask this cycle |
| out_result | output | XLEN | One-hot class mask in bits 9:0, zero above |

## Verification
The assertions assume that the upstream source keeps `in_data` meaningful whenever `in_valid` is high, and that the input-side class checks only look at cycles where an operand is actually accepted. The properties do not assume that the consumer is fair. The bench keeps to these assumptions by driving `in_data` and `in_valid` together on the falling edge. It raises `in_valid` only with a defined operand, and it holds `out_ready` low only in the stall scenario, where the stall is always released afterwards.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int HALF_W  = 16;
  localparam int EXP_W   = 5;
  localparam int MAN_W   = 10;
  localparam int CLASS_N = 10;

  // Bit positions of the class mask; the magnitude classes mirror around
  // the zero classes, negative side descending, positive side ascending.
  localparam int NEG_TOP  = 3;
  localparam int POS_BASE = 4;
  localparam int CLS_SNAN = 8;
  localparam int CLS_QNAN = 9;
  localparam int KIND_N   = 4;   // zero, subnormal, normal, infinity

  typedef struct packed {
    logic sign;
    logic exp_max;
    logic exp_zero;
    logic man_zero;
    logic man_msb;
  } hc_fields_t;
endpackage

// File: rtl/hc_field_split.sv
module hc_field_split
  import hc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] operand,
  output hc_fields_t     fields
);
  localparam int SIGN_POS = EW + MW;

  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;

  assign exp_f = operand[SIGN_POS-1:MW];
  assign man_f = operand[MW-1:0];

  always_comb begin
    fields.sign     = operand[SIGN_POS];
    fields.exp_max  = &exp_f;
    fields.exp_zero = ~|exp_f;
    fields.man_zero = ~|man_f;
    fields.man_msb  = man_f[MW-1];
  end
endmodule

// File: rtl/hc_mask_build.sv
module hc_mask_build
  import hc_pkg::*;
(
  input  hc_fields_t         fields,
  output logic [CLASS_N-1:0] mask
);
  logic [KIND_N-1:0] kind;
  logic              is_nan;

  always_comb begin
    kind[0] = fields.exp_zero &  fields.man_zero;
    kind[1] = fields.exp_zero & ~fields.man_zero;
    kind[2] = ~fields.exp_zero & ~fields.exp_max;
    kind[3] = fields.exp_max  &  fields.man_zero;
    is_nan  = fields.exp_max  & ~fields.man_zero;
  end

  for (genvar k = 0; k < KIND_N; k++) begin : g_kind
    assign mask[NEG_TOP - k]  =  fields.sign & kind[k];
    assign mask[POS_BASE + k] = ~fields.sign & kind[k];
  end

  assign mask[CLS_SNAN] = is_nan & ~fields.man_msb;
  assign mask[CLS_QNAN] = is_nan &  fields.man_msb;
endmodule

// File: rtl/hc_out_stage.sv
module hc_out_stage #(
  parameter int W          = 10,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  if (REGISTERED) begin : g_reg
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign s_ready = ~vld_q | m_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (s_ready) begin
        vld_q <= s_valid;
        if (s_valid) dat_q <= s_data;
      end
    end

    assign m_valid = vld_q;
    assign m_data  = dat_q;
  end else begin : g_comb
    assign s_ready = m_ready;
    assign m_valid = s_valid;
    assign m_data  = s_data;
  end
endmodule

// File: rtl/half_class_unit.sv
module half_class_unit
  import hc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [15:0]     in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result
);
  localparam int PAD_W = XLEN - CLASS_N;

  hc_fields_t         fields;
  logic [CLASS_N-1:0] mask_c;
  logic [CLASS_N-1:0] mask_q;

  hc_field_split #(.EW(EXP_W), .MW(MAN_W)) u_split (
    .operand (in_data),
    .fields  (fields)
  );

  hc_mask_build u_mask (
    .fields (fields),
    .mask   (mask_c)
  );

  hc_out_stage #(.W(CLASS_N), .REGISTERED(REGISTERED)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (mask_c),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (mask_q)
  );

  assign out_result = {{PAD_W{1'b0}}, mask_q};
endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
  parameter int XLEN       = 64,
  parameter bit REGISTERED = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [15:0]     in_data,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result
);
  logic take;
  assign take = in_valid & in_ready;

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_result[9:0]) == 1) && (out_result[XLEN-1:10] == '0));

  if (REGISTERED) begin : g_reg_props
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_result));

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

    p_qnan_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take && (&in_data[14:10]) && in_data[9] |=> out_result[9]);

    p_negzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take && (in_data == 16'h8000) |=> out_result[3]);

    p_neginf_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take && (in_data == 16'hfc00) |=> out_result[0]);
  end else begin : g_comb_props
    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);

    p_qnan_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (&in_data[14:10]) && in_data[9] |-> out_result[9]);

    p_negzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_data == 16'h8000) |-> out_result[3]);

    p_neginf_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_data == 16'hfc00) |-> out_result[0]);
  end
endmodule

bind half_class_unit hc_checker #(.XLEN(XLEN), .REGISTERED(REGISTERED)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/tb_half_class_unit.sv
`timescale 1ns/1ps
module tb_half_class_unit;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [15:0]     in_data = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [XLEN-1:0] out_result;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  half_class_unit #(.XLEN(XLEN), .REGISTERED(1'b1)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
  );

  // Expected mask from the requirement text.
  function automatic logic [XLEN-1:0] ref_mask(input logic [15:0] h);
    logic       s;
    logic [4:0] e;
    logic [9:0] m;
    int         b;
    s = h[15]; e = h[14:10]; m = h[9:0];
    if (e == 5'h1f && m != 0) b = m[9] ? 9 : 8;
    else if (e == 5'h1f)      b = s ? 0 : 7;
    else if (e == 0 && m == 0) b = s ? 3 : 4;
    else if (e == 0)          b = s ? 2 : 5;
    else                      b = s ? 1 : 6;
    return {{(XLEN-1){1'b0}}, 1'b1} << b;
  endfunction

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One operand through an empty stage; checks latency and value.
  task automatic send_one(input string tag, input logic [15:0] v);
    @(negedge clk);
    in_data = v; in_valid = 1'b1;
    chk({tag, " R9 not early"}, {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, {63'd0, out_valid}, 64'd1);
    chk(tag, out_result, ref_mask(v));
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_named;
    send_one("R1 0xfc00", 16'hfc00);
    chk("R1 bit0", out_result, 64'h1);
    send_one("R2 0xbc00", 16'hbc00);
    chk("R2 bit1", out_result, 64'h2);
    send_one("R2 0xfbff", 16'hfbff);
    send_one("R3 0x83ff", 16'h83ff);
    chk("R3 bit2", out_result, 64'h4);
    send_one("R3 0x8000", 16'h8000);
    chk("R3 bit3", out_result, 64'h8);
    send_one("R4 0x0000", 16'h0000);
    chk("R4 bit4", out_result, 64'h10);
    send_one("R4 0x03ff", 16'h03ff);
    chk("R4 bit5", out_result, 64'h20);
    send_one("R4 0x0001", 16'h0001);
    send_one("R5 0x3c00", 16'h3c00);
    chk("R5 bit6", out_result, 64'h40);
    send_one("R5 0x0400", 16'h0400);
    send_one("R5 0x7bff", 16'h7bff);
    send_one("R5 0x7c00", 16'h7c00);
    chk("R5 bit7", out_result, 64'h80);
    send_one("R6 0x7c01", 16'h7c01);
    chk("R6 bit8", out_result, 64'h100);
    send_one("R6 0xfc01", 16'hfc01);
    chk("R6 neg bit8", out_result, 64'h100);
    send_one("R7 0x7e00", 16'h7e00);
    chk("R7 bit9", out_result, 64'h200);
    send_one("R7 0xfe00", 16'hfe00);
    chk("R7 neg bit9", out_result, 64'h200);
  endtask

  // All patterns streamed one per cycle (R8, R9 throughput).
  task automatic t_sweep;
    logic [15:0] prev;
    prev = '0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R9 stream valid", {63'd0, out_valid}, 64'd1);
        chk("R8 sweep", out_result, ref_mask(prev));
      end
      in_data = 16'(i); in_valid = 1'b1;
      prev = 16'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 sweep last", out_result, ref_mask(prev));
    @(negedge clk);
    chk("R9 drain", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_data = 16'h7c00; in_valid = 1'b1;
    @(negedge clk);
    chk("R10 first held valid", {63'd0, out_valid}, 64'd1);
    chk("R10 first value", out_result, 64'h80);
    chk("R10 in_ready low", {63'd0, in_ready}, 64'd0);
    in_data = 16'h8000;
    @(negedge clk);
    chk("R10 still valid", {63'd0, out_valid}, 64'd1);
    chk("R10 not overwritten", out_result, 64'h80);
    @(negedge clk);
    chk("R10 still held", out_result, 64'h80);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 released next", out_result, 64'h8);
    chk("R10 released valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R10 empty", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_named();
    t_stall();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule